// File: doc/BRIEF.md
# Shared Interrupt Source Router

This block is the interrupt front end of a small 8-bit microcontroller. Four interrupt vectors are each shared by two possible owners. One owner is a peripheral request: SPI receive/overrun, I2C, multiply-accumulate overflow, or ADC/port change. The other owner is one of four timer compare units. A 2-bit mode field per compare unit decides who owns each vector. When a unit is in compare mode, its output drives the vector and the peripheral request is blocked. The other three vectors are not affected.

The block holds two interrupt-enable special function registers and a compare-mode register, all reached through a simple SFR write port with a combinational read-back. For each vector it selects a source, gates it with the vector's enable bit and records a rising edge in a pending flag. It then offers the CPU the highest-priority pending vector address until the CPU acknowledges it. A write of 1 to a self-clearing watchdog bit produces a one-cycle start strobe, or a refresh strobe when the watchdog was armed just before the write.

Top module: `irq_share_router`

## Requirements
- R1: After reset, all three registers read 0, `irq_valid` is 0, `irq_vector` is 0000h and both watchdog strobes are 0.
- R2: The enable-1 register at SFR address E8h stores bit 7 (timer-2 external enable), bit 5 (ADC/port enable), bit 4 (multiply-accumulate overflow enable), bit 3 (I2C enable), bit 2 (SPI receive enable) and bit 1 (SPI transmit-empty enable). Bit 6 (watchdog kick) and bit 0 (reserved) always read back as 0.
- R3: The enable-2 register at SFR address 9Ah stores only bit 0 (UART 1 enable). Bits 7 to 1 ignore writes and read back as 0.
- R4: The compare-mode register at SFR address C1h stores 8 bits. Bits 2n+1 and 2n form the field of unit n, and the value 2'b10 selects compare mode. Any other value, including 2'b11, leaves vector n with its peripheral.
- R5: Vector n (0 = SPI receive, 1 = I2C, 2 = multiply-accumulate, 3 = ADC/port) follows `periph_req[n]` and ignores `cmp_req[n]` unless its field is 2'b10. With the field at 2'b10 it follows `cmp_req[n]` and the peripheral request is blocked.
- R6: Compare mode on one unit redirects only that unit's vector. The other vectors keep their peripheral sources.
- R7: Vector n's selected request is gated by enable-1 bit n+2. A disabled request sets no pending flag. Enabling a request that is already high counts as a rising edge.
- R8: A pending flag is set on a rising edge of the gated request and cleared when that vector is acknowledged. A request held high after its acknowledge does not set the flag again.
- R9: Among pending vectors the lowest address wins. The address of vector n is 0053h + 8*n. `irq_vector` is 0000h while `irq_valid` is 0.
- R10: `irq_valid` stays 1 until `irq_ack` is given. An acknowledge clears only the presented vector, and the next pending vector is then offered.
- R11: Writing E8h with bit 6 set gives a one-cycle strobe in the following cycle. The strobe is `wdt_refresh` if a `wdt_arm` pulse occurred at or after the previous SFR write, and `wdt_start` otherwise.
- R12: `en_t2ex`, `en_spi_tx` and `en_uart1` reflect enable-1 bit 7, enable-1 bit 1 and enable-2 bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_we | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address for write and read |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | Read-back of the addressed register |
| wdt_arm | input | 1 | Pulse when the external watchdog-arm bit is set |
| periph_req | input | 4 | Peripheral requests, index = vector |
| cmp_req | input | 4 | Compare-unit requests, index = vector |
| irq_ack | input | 1 | CPU acknowledges the presented vector |
| irq_valid | output | 1 | A vector is pending |
| irq_vector | output | 16 | Address of the highest-priority pending vector |
| wdt_start | output | 1 | One-cycle watchdog start strobe |
| wdt_refresh | output | 1 | One-cycle watchdog refresh strobe |
| en_t2ex | output | 1 | Timer-2 external interrupt enable |
| en_spi_tx | output | 1 | SPI transmit-empty interrupt enable |
| en_uart1 | output | 1 | UART 1 interrupt enable |

## Verification
The bench puts unit 2 alone in compare mode and checks that only the multiply-accumulate vector changes owner. A design that decoded the fields jointly, or swapped field bits, would lose the other vectors or block the wrong one. It also sets a field to 2'b11, where a design that tested a single bit would hand the vector to the compare unit. It holds requests high across an acknowledge and enables a request that is already high: a level-sensitive design would re-interrupt forever in the first case, and an edge detector placed before the gate would miss the second. It leaves two vectors pending, where a wrong priority or an acknowledge that clears every flag shows up in the scoreboard order. It also writes another register between the arm pulse and the kick, which must turn a refresh into a start.

// File: rtl/irq_share_pkg.sv
package irq_share_pkg;
  localparam int SFR_W = 8;

  typedef enum logic [1:0] {
    CM_OFF     = 2'b00,
    CM_CAPTURE = 2'b01,
    CM_COMPARE = 2'b10,
    CM_RSVD    = 2'b11
  } cc_mode_e;

  // Bit positions in the enable-1 register
  localparam int EN1_T2EX_BIT  = 7;
  localparam int EN1_KICK_BIT  = 6;
  localparam int EN1_VEC_LSB   = 2;
  localparam int EN1_SPITX_BIT = 1;

  // Storable bits of each register
  localparam logic [SFR_W-1:0] EN1_MASK = 8'hBE;
  localparam logic [SFR_W-1:0] EN2_MASK = 8'h01;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_share_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] ADDR_EN1  = 8'hE8,
  parameter logic [ADDR_W-1:0] ADDR_EN2  = 8'h9A,
  parameter logic [ADDR_W-1:0] ADDR_CMPM = 8'hC1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SFR_W-1:0]  wdata,
  input  logic              wdt_arm,
  output logic [SFR_W-1:0]  rdata,
  output logic [SFR_W-1:0]  en1_q,
  output logic [SFR_W-1:0]  en2_q,
  output logic [SFR_W-1:0]  cmpm_q,
  output logic              kick_start_q,
  output logic              kick_refresh_q
);
  logic [SFR_W-1:0] en1_d, en2_d, cmpm_d;
  logic             armed_q, armed_d;
  logic             kick_start_d, kick_refresh_d;
  logic             wr_en1, wr_en2, wr_cmpm, kick, armed_now;

  always_comb begin
    wr_en1    = we && (addr == ADDR_EN1);
    wr_en2    = we && (addr == ADDR_EN2);
    wr_cmpm   = we && (addr == ADDR_CMPM);
    kick      = wr_en1 && wdata[EN1_KICK_BIT];
    armed_now = armed_q || wdt_arm;

    en1_d  = wr_en1  ? (wdata & EN1_MASK) : en1_q;
    en2_d  = wr_en2  ? (wdata & EN2_MASK) : en2_q;
    cmpm_d = wr_cmpm ? wdata              : cmpm_q;

    // any SFR write consumes the arm state
    armed_d        = we ? 1'b0 : armed_now;
    kick_refresh_d = kick && armed_now;
    kick_start_d   = kick && !armed_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en1_q          <= '0;
      en2_q          <= '0;
      cmpm_q         <= '0;
      armed_q        <= 1'b0;
      kick_start_q   <= 1'b0;
      kick_refresh_q <= 1'b0;
    end else begin
      en1_q          <= en1_d;
      en2_q          <= en2_d;
      cmpm_q         <= cmpm_d;
      armed_q        <= armed_d;
      kick_start_q   <= kick_start_d;
      kick_refresh_q <= kick_refresh_d;
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_EN1:  rdata = en1_q;
      ADDR_EN2:  rdata = en2_q;
      ADDR_CMPM: rdata = cmpm_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_vec_slot.sv
module irq_vec_slot
  import irq_share_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       enable,
  input  logic       periph,
  input  logic       cmp,
  input  logic       ack,
  output logic       pend_q
);
  logic sel_req, gated, gated_q, pend_d;

  always_comb begin
    sel_req = (mode == CM_COMPARE) ? cmp : periph;
    gated   = sel_req && enable;
    // a fresh edge wins over a same-cycle acknowledge
    pend_d  = (gated && !gated_q) || (pend_q && !ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gated_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      gated_q <= gated;
      pend_q  <= pend_d;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_VEC = 4,
  parameter int VEC_W   = 16,
  parameter logic [VEC_W-1:0] VEC_BASE = 16'h0053,
  parameter int VEC_STEP = 8
) (
  input  logic [NUM_VEC-1:0] pend,
  output logic [NUM_VEC-1:0] grant,
  output logic               valid,
  output logic [VEC_W-1:0]   vector
);
  localparam int IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  logic [IDX_W-1:0] idx;
  logic             found;

  always_comb begin
    grant = '0;
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (pend[i] && !found) begin
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
        found    = 1'b1;
      end
    end
    valid  = found;
    vector = found ? (VEC_BASE + VEC_W'(idx) * VEC_W'(VEC_STEP)) : '0;
  end
endmodule

// File: rtl/irq_share_router.sv
module irq_share_router
  import irq_share_pkg::*;
#(
  parameter int NUM_VEC  = 4,
  parameter int ADDR_W   = 8,
  parameter int VEC_W    = 16,
  parameter logic [VEC_W-1:0] VEC_BASE = 16'h0053,
  parameter int VEC_STEP = 8,
  parameter logic [ADDR_W-1:0] ADDR_EN1  = 8'hE8,
  parameter logic [ADDR_W-1:0] ADDR_EN2  = 8'h9A,
  parameter logic [ADDR_W-1:0] ADDR_CMPM = 8'hC1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sfr_we,
  input  logic [ADDR_W-1:0]  sfr_addr,
  input  logic [SFR_W-1:0]   sfr_wdata,
  output logic [SFR_W-1:0]   sfr_rdata,
  input  logic               wdt_arm,
  input  logic [NUM_VEC-1:0] periph_req,
  input  logic [NUM_VEC-1:0] cmp_req,
  input  logic               irq_ack,
  output logic               irq_valid,
  output logic [VEC_W-1:0]   irq_vector,
  output logic               wdt_start,
  output logic               wdt_refresh,
  output logic               en_t2ex,
  output logic               en_spi_tx,
  output logic               en_uart1
);
  logic [SFR_W-1:0]   en1_q, en2_q, cmpm_q;
  logic [NUM_VEC-1:0] pend, grant, slot_ack;

  irq_cfg_regs #(
    .ADDR_W(ADDR_W), .ADDR_EN1(ADDR_EN1), .ADDR_EN2(ADDR_EN2), .ADDR_CMPM(ADDR_CMPM)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .we(sfr_we), .addr(sfr_addr), .wdata(sfr_wdata),
    .wdt_arm(wdt_arm), .rdata(sfr_rdata), .en1_q(en1_q), .en2_q(en2_q),
    .cmpm_q(cmpm_q), .kick_start_q(wdt_start), .kick_refresh_q(wdt_refresh)
  );

  always_comb slot_ack = grant & {NUM_VEC{irq_ack}};

  for (genvar n = 0; n < NUM_VEC; n++) begin : g_slot
    irq_vec_slot i_slot (
      .clk(clk), .rst_n(rst_n),
      .mode(cmpm_q[2*n +: 2]),
      .enable(en1_q[EN1_VEC_LSB + n]),
      .periph(periph_req[n]), .cmp(cmp_req[n]),
      .ack(slot_ack[n]), .pend_q(pend[n])
    );
  end

  irq_prio_enc #(
    .NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) i_prio (
    .pend(pend), .grant(grant), .valid(irq_valid), .vector(irq_vector)
  );

  always_comb begin
    en_t2ex   = en1_q[EN1_T2EX_BIT];
    en_spi_tx = en1_q[EN1_SPITX_BIT];
    en_uart1  = en2_q[0];
  end
endmodule

// File: rtl/irq_share_chk.sv
module irq_share_chk #(
  parameter int ADDR_W = 8,
  parameter int VEC_W  = 16,
  parameter logic [VEC_W-1:0]  VEC_BASE = 16'h0053,
  parameter logic [ADDR_W-1:0] ADDR_EN1 = 8'hE8,
  parameter logic [ADDR_W-1:0] ADDR_EN2 = 8'h9A
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sfr_we,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic [7:0]        sfr_wdata,
  input logic [7:0]        sfr_rdata,
  input logic              irq_ack,
  input logic              irq_valid,
  input logic [VEC_W-1:0]  irq_vector,
  input logic              wdt_start,
  input logic              wdt_refresh
);
  AST_KICK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_start || wdt_refresh) |-> $past(sfr_we && sfr_addr == ADDR_EN1 && sfr_wdata[6])); // R11
  AST_KICK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wdt_start && wdt_refresh)); // R11
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ack) |=> irq_valid); // R10
  AST_IDLE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> (irq_vector == '0)); // R9
  AST_VECTOR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector >= VEC_BASE)); // R9
  AST_EN2_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == ADDR_EN2) |-> (sfr_rdata[7:1] == 7'd0)); // R3
  AST_EN1_FIXED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == ADDR_EN1) |-> (sfr_rdata[6] == 1'b0 && sfr_rdata[0] == 1'b0)); // R2
endmodule

bind irq_share_router irq_share_chk #(
  .ADDR_W(ADDR_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE),
  .ADDR_EN1(ADDR_EN1), .ADDR_EN2(ADDR_EN2)
) i_chk (.*);

// File: tb/test_irq_share_router.sv
module test_irq_share_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sfr_we = 1'b0;
  logic [7:0]  sfr_addr = '0;
  logic [7:0]  sfr_wdata = '0;
  logic [7:0]  sfr_rdata;
  logic        wdt_arm = 1'b0;
  logic [3:0]  periph_req = '0;
  logic [3:0]  cmp_req = '0;
  logic        irq_ack = 1'b0;
  logic        irq_valid;
  logic [15:0] irq_vector;
  logic        wdt_start, wdt_refresh, en_t2ex, en_spi_tx, en_uart1;

  int checks = 0;
  int failures = 0;
  logic [15:0] exp_vec_q[$];
  string       exp_tag_q[$];

  always #2.5 clk = ~clk;

  irq_share_router i_irq_share_router (
    .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .wdt_arm(wdt_arm),
    .periph_req(periph_req), .cmp_req(cmp_req), .irq_ack(irq_ack),
    .irq_valid(irq_valid), .irq_vector(irq_vector), .wdt_start(wdt_start),
    .wdt_refresh(wdt_refresh), .en_t2ex(en_t2ex), .en_spi_tx(en_spi_tx),
    .en_uart1(en_uart1)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic sfr_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk); sfr_we = 1'b0;
  endtask

  task automatic sfr_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); sfr_addr = a; #1 d = sfr_rdata;
  endtask

  task automatic set_p(input int n, input logic v);
    @(negedge clk); periph_req[n] = v; @(negedge clk);
  endtask

  task automatic set_c(input int n, input logic v);
    @(negedge clk); cmp_req[n] = v; @(negedge clk);
  endtask

  // driver: push the expected vector, then acknowledge
  task automatic take(input logic [15:0] v, input string tag);
    exp_vec_q.push_back(v); exp_tag_q.push_back(tag);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  // monitor: compare the offered vector at each acknowledge
  always @(negedge clk) begin
    #1;
    if (irq_ack) begin
      if (exp_vec_q.size() == 0) chk("R10 unexpected ack", 32'(irq_vector), 32'hFFFF);
      else begin
        string t; logic [15:0] e;
        t = exp_tag_q.pop_front(); e = exp_vec_q.pop_front();
        chk({t, " scoreboard vector"}, 32'(irq_vector), 32'(e));
        chk({t, " valid at ack"}, 32'(irq_valid), 32'd1);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 valid", 32'(irq_valid), 0);
    chk("R1 vector", 32'(irq_vector), 0);
    chk("R1 strobes", 32'({wdt_start, wdt_refresh}), 0);
    sfr_rd(8'hE8, d); chk("R1 en1", 32'(d), 0);
    sfr_rd(8'h9A, d); chk("R1 en2", 32'(d), 0);
    sfr_rd(8'hC1, d); chk("R1 cmpm", 32'(d), 0);

    sfr_wr(8'hE8, 8'hFF); sfr_rd(8'hE8, d); chk("R2 en1 readback", 32'(d), 32'hBE);
    chk("R12 t2ex/spitx", 32'({en_t2ex, en_spi_tx}), 32'h3);
    sfr_wr(8'h9A, 8'hFF); sfr_rd(8'h9A, d); chk("R3 en2 readback", 32'(d), 32'h01);
    chk("R12 uart1", 32'(en_uart1), 1);
    sfr_wr(8'hC1, 8'hA5); sfr_rd(8'hC1, d); chk("R4 cmpm readback", 32'(d), 32'hA5);
    sfr_wr(8'hC1, 8'h00);

    set_p(0, 1'b1);
    chk("R5 periph0 valid", 32'(irq_valid), 1);
    chk("R9 vec0 address", 32'(irq_vector), 32'h53);
    take(16'h0053, "R8");
    chk("R8 cleared by ack", 32'(irq_valid), 0);
    repeat (3) @(negedge clk);
    chk("R8 held request no repend", 32'(irq_valid), 0);
    set_p(0, 1'b0);
    set_c(0, 1'b1);
    chk("R5 compare ignored in mode 00", 32'(irq_valid), 0);
    set_c(0, 1'b0);

    sfr_wr(8'hC1, 8'h20);
    set_p(2, 1'b1);
    chk("R5 periph2 blocked", 32'(irq_valid), 0);
    set_c(2, 1'b1);
    chk("R5 compare2 routed", 32'(irq_vector), 32'h63);
    set_p(1, 1'b1);
    chk("R9 lower address wins", 32'(irq_vector), 32'h5B);
    take(16'h005B, "R6");
    chk("R10 next vector offered", 32'(irq_vector), 32'h63);
    take(16'h0063, "R5");
    chk("R10 all served", 32'(irq_valid), 0);
    set_p(3, 1'b1);
    chk("R6 vec3 keeps periph", 32'(irq_vector), 32'h6B);
    repeat (4) @(negedge clk);
    chk("R10 valid held without ack", 32'(irq_valid), 1);
    take(16'h006B, "R6");
    set_p(1, 1'b0); set_p(2, 1'b0); set_c(2, 1'b0); set_p(3, 1'b0);

    sfr_wr(8'hC1, 8'hC0);
    set_c(3, 1'b1);
    chk("R4 field 11 not compare", 32'(irq_valid), 0);
    set_p(3, 1'b1);
    chk("R4 field 11 periph active", 32'(irq_vector), 32'h6B);
    take(16'h006B, "R4");
    set_p(3, 1'b0); set_c(3, 1'b0);

    sfr_wr(8'hE8, 8'h9E);
    set_p(3, 1'b1);
    chk("R7 disabled no pending", 32'(irq_valid), 0);
    sfr_wr(8'hE8, 8'hBE);
    @(negedge clk);
    chk("R7 enable on high request", 32'(irq_vector), 32'h6B);
    take(16'h006B, "R7");
    set_p(3, 1'b0);

    sfr_wr(8'hE8, 8'hFE);
    chk("R11 start strobe", 32'({wdt_start, wdt_refresh}), 32'h2);
    @(negedge clk); #1;
    chk("R11 start one cycle", 32'({wdt_start, wdt_refresh}), 0);
    sfr_rd(8'hE8, d); chk("R2 kick bit reads 0", 32'(d[6]), 0);
    @(negedge clk); wdt_arm = 1'b1; @(negedge clk); wdt_arm = 1'b0;
    sfr_wr(8'hE8, 8'hFE);
    chk("R11 refresh strobe", 32'({wdt_start, wdt_refresh}), 32'h1);
    @(negedge clk); #1;
    chk("R11 refresh one cycle", 32'({wdt_start, wdt_refresh}), 0);
    @(negedge clk); wdt_arm = 1'b1; @(negedge clk); wdt_arm = 1'b0;
    sfr_wr(8'h9A, 8'h01);
    sfr_wr(8'hE8, 8'hFE);
    chk("R11 arm consumed by other write", 32'({wdt_start, wdt_refresh}), 32'h2);

    repeat (2) @(negedge clk);
    chk("R10 scoreboard drained", 32'(exp_vec_q.size()), 0);
    summary();
    $finish;
  end
endmodule